// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block sequences the power state of a small microcontroller core. It watches the CPU's sleep requests: wait-for-interrupt, wait-for-event, and the return from an interrupt handler with sleep-on-exit armed. It also reads a set of software configuration bits: a deep-sleep flag, a 3-bit mode select, an SRAM keep bit and a low-power regulator run bit. From these inputs it chooses one of eight power states and drives the matching clock-gate enables, regulator enables, SRAM retention enable and wakeup clock choice.

Each power state admits its own set of wakeup sources.
- Light sleep ends on an interrupt, or on an event when it was entered by wait-for-event.
- The two stop states end on an unmasked external line or on a peripheral wake request.
- Standby and shutdown end on a wake pin edge, a timekeeping event, a tamper event or the external reset pin. Standby also accepts the watchdog.

Leaving standby or shutdown does not resume execution. It raises a system reset request for a fixed number of cycles and sets a sticky flag that records the standby exit. Deep-sleep entry is refused while any deep wake source is already active, so a wakeup that arrives during entry cannot be lost.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the state code `cur_mode` is 0 (run). The encodings are: run 0, low-power run 1, sleep 2, low-power sleep 3, stop-with-main-regulator 4, stop-with-main-regulator-off 5, standby 6, shutdown 7, reset request 8. In run, every clock, both regulators and SRAM retention are enabled, `wake_clk_sel` is 0, and `sys_reset_req` and `stby_flag` are low.
- R2: When `deep_sleep` is low, `sleep_wfi` or `sleep_isr_exit` enters sleep (2). In sleep only `cpu_clk_en` drops, and any bit of `irq_pend` returns the block to run without a reset request.
- R3: When `deep_sleep` is low, `sleep_wfe` alone enters sleep. `irq_pend` is then ignored, and only `wake_event` ends it.
- R4: While `lp_reg_run` is high and no sleep is requested, the state is low-power run (1). In that state `main_reg_en` is low, while `lp_reg_en` and all clocks stay on. Clearing `lp_reg_run` returns to run on the next clock.
- R5: A sleep request while `lp_reg_run` is high enters low-power sleep (3). In that state the CPU clock is off, the main regulator is off, and the wake rules of R2/R3 apply.
- R6: When `deep_sleep` is high, `lpm_sel` 000 enters state 4 with `main_reg_en` high, and 001 enters state 5 with `main_reg_en` low. In both states only `lsi_en` and `lse_en` remain among the clocks.
- R7: A stop state ends only on a set `exti_pend` bit whose `exti_mask` bit is 1, or on `periph_wake`. While in stop, `wake_clk_sel` is 1, which selects the internal high-speed oscillator.
- R8: `lpm_sel` 011 enters standby (6) with both regulators off. `sram_ret_en` follows the value of `sram_keep` captured at entry.
- R9: `lpm_sel` with bit 2 set enters shutdown (7). In shutdown only `lse_en` stays high, and SRAM retention and both regulators are off.
- R10: Standby wakes on a rising edge of any `wkup_pin` bit, on `rtc_evt`, `tamp_evt`, `pin_rst_req` or `wdg_rst_req`. Shutdown ignores `wdg_rst_req` but accepts the others. In both deep states `wake_clk_sel` is 2.
- R11: `lpm_sel` 010 is reserved. It enters state 5, and `mode_reserved` stays high for as long as that stop lasts.
- R12: A wake from standby or shutdown enters state 8. In state 8 `sys_reset_req` is high for exactly RST_CYCLES cycles, after which the block returns to run. `stby_flag` sets at that wake and stays set until reset.
- R13: A deep-sleep request is refused, and the block stays in run or low-power run, while any stop, standby or shutdown wake source is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_wfi | input | 1 | Wait-for-interrupt request |
| sleep_wfe | input | 1 | Wait-for-event request |
| sleep_isr_exit | input | 1 | Return from handler with sleep-on-exit |
| deep_sleep | input | 1 | Deep-sleep flag |
| lpm_sel | input | 3 | Deep mode select |
| sram_keep | input | 1 | Keep SRAM powered in standby |
| lp_reg_run | input | 1 | Run from the low-power regulator |
| irq_pend | input | N_IRQ | Pending interrupts |
| wake_event | input | 1 | Wakeup event |
| exti_pend | input | N_EXTI | External line pending bits |
| exti_mask | input | N_EXTI | External line enables (1 = enabled) |
| periph_wake | input | 1 | Peripheral wake request |
| wkup_pin | input | N_WKUP | Wake pins, rising-edge sensitive |
| rtc_evt | input | 1 | Timekeeping event |
| tamp_evt | input | 1 | Tamper event |
| pin_rst_req | input | 1 | External reset pin request |
| wdg_rst_req | input | 1 | Independent watchdog reset request |
| cur_mode | output | 4 | Current state code |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_clk_en | output | 1 | Bus and peripheral clock enable |
| hs_osc_en | output | 1 | High-speed oscillator enable |
| lsi_en | output | 1 | Internal low-speed oscillator enable |
| lse_en | output | 1 | External low-speed oscillator enable |
| main_reg_en | output | 1 | Main regulator enable |
| lp_reg_en | output | 1 | Low-power regulator enable |
| sram_ret_en | output | 1 | SRAM retention enable |
| wake_clk_sel | output | 2 | Wake clock: 0 keep, 1 internal HS, 2 boot default |
| sys_reset_req | output | 1 | System reset request |
| stby_flag | output | 1 | Sticky standby-exit flag |
| mode_reserved | output | 1 | Reserved select in use |

## Verification
The assertions assume that the sleep request lines are sampled only in run or low-power run. They also assume that the wake inputs behave as levels, except `wkup_pin`, which is edge-detected inside the block. The hold-off property relies on the timekeeping, tamper, watchdog, reset pin and peripheral inputs counting as pending deep sources whenever they are high. The bench drives every input one nanosecond after a rising edge and returns all of them to zero through its reset task. Each request is a single-cycle pulse given from a settled run state, so no request overlaps a state transition that was not intended.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [3:0] {
        M_RUN     = 4'd0,
        M_LPRUN   = 4'd1,
        M_SLEEP   = 4'd2,
        M_LPSLEEP = 4'd3,
        M_STOP0   = 4'd4,
        M_STOP1   = 4'd5,
        M_STBY    = 4'd6,
        M_SHUT    = 4'd7,
        M_RSTREQ  = 4'd8
    } pmode_e;

    typedef enum logic [1:0] {
        WCLK_KEEP = 2'd0,
        WCLK_HSI  = 2'd1,
        WCLK_BOOT = 2'd2
    } wclk_e;

    typedef struct packed {
        logic cpu;
        logic sys;
        logic hso;
        logic lsi;
        logic lse;
        logic mreg;
        logic lreg;
        logic sram;
    } pwr_knobs_t;

    // Deep target from the select field; 010 is reserved and folds onto stop 1.
    function automatic pmode_e deep_target(input logic [2:0] sel);
        pmode_e m;
        if (sel[2])               m = M_SHUT;
        else if (sel[1:0] == 2'b11) m = M_STBY;
        else if (sel[1:0] == 2'b00) m = M_STOP0;
        else                      m = M_STOP1;
        return m;
    endfunction

    function automatic logic sel_reserved(input logic [2:0] sel);
        return sel == 3'b010;
    endfunction

    function automatic logic is_light(input pmode_e m);
        return (m == M_SLEEP) || (m == M_LPSLEEP);
    endfunction

    function automatic logic is_stop(input pmode_e m);
        return (m == M_STOP0) || (m == M_STOP1);
    endfunction

endpackage

// File: rtl/lpm_entry_dec.sv
module lpm_entry_dec
    import lpm_pkg::*;
(
    input  logic       deep,
    input  logic [2:0] sel,
    input  logic       lpr,
    input  logic       wfi,
    input  logic       wfe,
    input  logic       isr_exit,
    output pmode_e     target,
    output logic       req_any,
    output logic       evt_only,
    output logic       rsv
);
    always_comb begin
        req_any  = wfi | wfe | isr_exit;
        // wait-for-event alone arms event-only wake; interrupt requests win
        evt_only = wfe & ~(wfi | isr_exit);
        rsv      = deep & sel_reserved(sel);
        if (deep)     target = deep_target(sel);
        else if (lpr) target = M_LPSLEEP;
        else          target = M_SLEEP;
    end
endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
    import lpm_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int N_EXTI = 16,
    parameter int N_WKUP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  pmode_e            mode,
    input  logic              evt_wait,
    input  logic [N_IRQ-1:0]  irq_pend,
    input  logic              wake_event,
    input  logic [N_EXTI-1:0] exti_pend,
    input  logic [N_EXTI-1:0] exti_mask,
    input  logic              periph_wake,
    input  logic [N_WKUP-1:0] wkup_pin,
    input  logic              rtc_evt,
    input  logic              tamp_evt,
    input  logic              pin_rst_req,
    input  logic              wdg_rst_req,
    output logic              wake_hit,
    output logic              deep_pending
);
    logic [N_WKUP-1:0] pin_q;
    logic [N_WKUP-1:0] pin_rise;

    for (genvar g = 0; g < N_WKUP; g++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) pin_q[g] <= 1'b0;
            else     pin_q[g] <= wkup_pin[g];
        end
        assign pin_rise[g] = wkup_pin[g] & ~pin_q[g];
    end

    logic light_src, stop_src, shut_src, stby_src;

    always_comb begin
        light_src = evt_wait ? wake_event : (|irq_pend);
        stop_src  = (|(exti_pend & exti_mask)) | periph_wake;
        shut_src  = (|pin_rise) | rtc_evt | tamp_evt | pin_rst_req;
        stby_src  = shut_src | wdg_rst_req;
        deep_pending = stop_src | stby_src;
        unique case (mode)
            M_SLEEP, M_LPSLEEP: wake_hit = light_src;
            M_STOP0, M_STOP1:   wake_hit = stop_src;
            M_STBY:             wake_hit = stby_src;
            M_SHUT:             wake_hit = shut_src;
            default:            wake_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/lpm_out_map.sv
module lpm_out_map
    import lpm_pkg::*;
(
    input  pmode_e     mode,
    input  logic       keep,
    output pwr_knobs_t knobs,
    output wclk_e      wclk
);
    always_comb begin
        knobs = '1;
        wclk  = WCLK_KEEP;
        unique case (mode)
            M_RUN:     knobs = '1;
            M_LPRUN:   knobs.mreg = 1'b0;
            M_SLEEP:   knobs.cpu  = 1'b0;
            M_LPSLEEP: begin
                knobs.cpu  = 1'b0;
                knobs.mreg = 1'b0;
            end
            M_STOP0, M_STOP1: begin
                knobs.cpu  = 1'b0;
                knobs.sys  = 1'b0;
                knobs.hso  = 1'b0;
                knobs.mreg = (mode == M_STOP0);
                wclk       = WCLK_HSI;
            end
            M_STBY: begin
                knobs      = '{cpu: 1'b0, sys: 1'b0, hso: 1'b0, lsi: 1'b1,
                               lse: 1'b1, mreg: 1'b0, lreg: 1'b0, sram: keep};
                wclk       = WCLK_BOOT;
            end
            M_SHUT: begin
                knobs      = '0;
                knobs.lse  = 1'b1;
                wclk       = WCLK_BOOT;
            end
            M_RSTREQ: begin
                knobs.cpu  = 1'b0;
                knobs.sys  = 1'b0;
                wclk       = WCLK_BOOT;
            end
            default:   knobs = '1;
        endcase
    end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int N_IRQ      = 8,
    parameter int N_EXTI     = 16,
    parameter int N_WKUP     = 2,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_wfi,
    input  logic              sleep_wfe,
    input  logic              sleep_isr_exit,
    input  logic              deep_sleep,
    input  logic [2:0]        lpm_sel,
    input  logic              sram_keep,
    input  logic              lp_reg_run,
    input  logic [N_IRQ-1:0]  irq_pend,
    input  logic              wake_event,
    input  logic [N_EXTI-1:0] exti_pend,
    input  logic [N_EXTI-1:0] exti_mask,
    input  logic              periph_wake,
    input  logic [N_WKUP-1:0] wkup_pin,
    input  logic              rtc_evt,
    input  logic              tamp_evt,
    input  logic              pin_rst_req,
    input  logic              wdg_rst_req,
    output logic [3:0]        cur_mode,
    output logic              cpu_clk_en,
    output logic              sys_clk_en,
    output logic              hs_osc_en,
    output logic              lsi_en,
    output logic              lse_en,
    output logic              main_reg_en,
    output logic              lp_reg_en,
    output logic              sram_ret_en,
    output logic [1:0]        wake_clk_sel,
    output logic              sys_reset_req,
    output logic              stby_flag,
    output logic              mode_reserved
);
    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(RST_CYCLES - 1);

    pmode_e        mode_q, mode_d, target;
    logic          evt_q, evt_d, keep_q, keep_d, rsv_q, rsv_d, flag_q, flag_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          req_any, evt_only, rsv_sel, wake_hit, deep_pending;
    pwr_knobs_t    knobs;
    wclk_e         wclk;

    lpm_entry_dec u_dec (
        .deep     (deep_sleep),
        .sel      (lpm_sel),
        .lpr      (lp_reg_run),
        .wfi      (sleep_wfi),
        .wfe      (sleep_wfe),
        .isr_exit (sleep_isr_exit),
        .target   (target),
        .req_any  (req_any),
        .evt_only (evt_only),
        .rsv      (rsv_sel)
    );

    lpm_wake_qual #(.N_IRQ(N_IRQ), .N_EXTI(N_EXTI), .N_WKUP(N_WKUP)) u_wake (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode_q),
        .evt_wait     (evt_q),
        .irq_pend     (irq_pend),
        .wake_event   (wake_event),
        .exti_pend    (exti_pend),
        .exti_mask    (exti_mask),
        .periph_wake  (periph_wake),
        .wkup_pin     (wkup_pin),
        .rtc_evt      (rtc_evt),
        .tamp_evt     (tamp_evt),
        .pin_rst_req  (pin_rst_req),
        .wdg_rst_req  (wdg_rst_req),
        .wake_hit     (wake_hit),
        .deep_pending (deep_pending)
    );

    lpm_out_map u_map (
        .mode  (mode_q),
        .keep  (keep_q),
        .knobs (knobs),
        .wclk  (wclk)
    );

    always_comb begin
        mode_d = mode_q;
        evt_d  = evt_q;
        keep_d = keep_q;
        rsv_d  = rsv_q;
        cnt_d  = cnt_q;
        flag_d = flag_q;
        unique case (mode_q)
            M_RUN, M_LPRUN: begin
                if (req_any && !(deep_sleep && deep_pending)) begin
                    mode_d = target;
                    evt_d  = evt_only;
                    keep_d = sram_keep;
                    rsv_d  = rsv_sel;
                end else begin
                    mode_d = lp_reg_run ? M_LPRUN : M_RUN;
                end
            end
            M_SLEEP, M_LPSLEEP, M_STOP0, M_STOP1: begin
                if (wake_hit) begin
                    mode_d = lp_reg_run ? M_LPRUN : M_RUN;
                    rsv_d  = 1'b0;
                end
            end
            M_STBY, M_SHUT: begin
                if (wake_hit) begin
                    mode_d = M_RSTREQ;
                    cnt_d  = '0;
                    flag_d = 1'b1;
                end
            end
            M_RSTREQ: begin
                if (cnt_q == CNT_LAST) mode_d = M_RUN;
                else                   cnt_d  = cnt_q + 1'b1;
            end
            default: mode_d = M_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= M_RUN;
            evt_q  <= 1'b0;
            keep_q <= 1'b1;
            rsv_q  <= 1'b0;
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            evt_q  <= evt_d;
            keep_q <= keep_d;
            rsv_q  <= rsv_d;
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
        end
    end

    assign cur_mode      = mode_q;
    assign cpu_clk_en    = knobs.cpu;
    assign sys_clk_en    = knobs.sys;
    assign hs_osc_en     = knobs.hso;
    assign lsi_en        = knobs.lsi;
    assign lse_en        = knobs.lse;
    assign main_reg_en   = knobs.mreg;
    assign lp_reg_en     = knobs.lreg;
    assign sram_ret_en   = knobs.sram;
    assign wake_clk_sel  = wclk;
    assign sys_reset_req = (mode_q == M_RSTREQ);
    assign stby_flag     = flag_q;
    assign mode_reserved = rsv_q;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       sleep_wfi,
    input logic       sleep_wfe,
    input logic       sleep_isr_exit,
    input logic       deep_sleep,
    input logic       rtc_evt,
    input logic       tamp_evt,
    input logic       wdg_rst_req,
    input logic       pin_rst_req,
    input logic       periph_wake,
    input logic [3:0] cur_mode,
    input logic       cpu_clk_en,
    input logic       sys_clk_en,
    input logic       hs_osc_en,
    input logic       lsi_en,
    input logic       lse_en,
    input logic       main_reg_en,
    input logic       lp_reg_en,
    input logic       sys_reset_req,
    input logic       stby_flag,
    input logic       mode_reserved
);
    // R1
    reset_run_chk: assert property (@(posedge clk) rst |=> cur_mode == 4'd0);

    // R2
    sleep_gate_chk: assert property (@(posedge clk) disable iff (rst)
        cur_mode == 4'd2 |-> !cpu_clk_en && sys_clk_en && hs_osc_en && main_reg_en);

    // R4
    lprun_reg_chk: assert property (@(posedge clk) disable iff (rst)
        cur_mode == 4'd1 |-> !main_reg_en && lp_reg_en && cpu_clk_en);

    // R6
    stop_clk_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 4'd4 || cur_mode == 4'd5) |->
            !sys_clk_en && !hs_osc_en && lsi_en && lse_en && (main_reg_en == (cur_mode == 4'd4)));

    // R9
    shut_only_lse_chk: assert property (@(posedge clk) disable iff (rst)
        cur_mode == 4'd7 |-> lse_en && !lsi_en && !main_reg_en && !lp_reg_en);

    // R11
    reserved_stop_chk: assert property (@(posedge clk) disable iff (rst)
        mode_reserved |-> cur_mode == 4'd5);

    // R12
    reset_from_deep_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_reset_req) |-> ($past(cur_mode) == 4'd6 || $past(cur_mode) == 4'd7));

    // R12
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        stby_flag |=> stby_flag);

    // R13
    holdoff_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_mode <= 4'd1) && deep_sleep && (sleep_wfi || sleep_wfe || sleep_isr_exit) &&
        (rtc_evt || tamp_evt || wdg_rst_req || pin_rst_req || periph_wake) |=> cur_mode <= 4'd1);
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .sleep_wfi      (sleep_wfi),
    .sleep_wfe      (sleep_wfe),
    .sleep_isr_exit (sleep_isr_exit),
    .deep_sleep     (deep_sleep),
    .rtc_evt        (rtc_evt),
    .tamp_evt       (tamp_evt),
    .wdg_rst_req    (wdg_rst_req),
    .pin_rst_req    (pin_rst_req),
    .periph_wake    (periph_wake),
    .cur_mode       (cur_mode),
    .cpu_clk_en     (cpu_clk_en),
    .sys_clk_en     (sys_clk_en),
    .hs_osc_en      (hs_osc_en),
    .lsi_en         (lsi_en),
    .lse_en         (lse_en),
    .main_reg_en    (main_reg_en),
    .lp_reg_en      (lp_reg_en),
    .sys_reset_req  (sys_reset_req),
    .stby_flag      (stby_flag),
    .mode_reserved  (mode_reserved)
);

// File: tb/test_lpm_ctrl.sv
module test_lpm_ctrl;
    localparam int N_IRQ = 8, N_EXTI = 16, N_WKUP = 2, RST_CYCLES = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, sleep_wfi, sleep_wfe, sleep_isr_exit, deep_sleep, sram_keep, lp_reg_run;
    logic [2:0] lpm_sel;
    logic [N_IRQ-1:0] irq_pend;
    logic wake_event, periph_wake, rtc_evt, tamp_evt, pin_rst_req, wdg_rst_req;
    logic [N_EXTI-1:0] exti_pend, exti_mask;
    logic [N_WKUP-1:0] wkup_pin;
    logic [3:0] cur_mode;
    logic cpu_clk_en, sys_clk_en, hs_osc_en, lsi_en, lse_en, main_reg_en, lp_reg_en, sram_ret_en;
    logic [1:0] wake_clk_sel;
    logic sys_reset_req, stby_flag, mode_reserved;

    lpm_ctrl #(.N_IRQ(N_IRQ), .N_EXTI(N_EXTI), .N_WKUP(N_WKUP), .RST_CYCLES(RST_CYCLES)) i_lpm_ctrl (
        .clk(clk), .rst(rst), .sleep_wfi(sleep_wfi), .sleep_wfe(sleep_wfe),
        .sleep_isr_exit(sleep_isr_exit), .deep_sleep(deep_sleep), .lpm_sel(lpm_sel),
        .sram_keep(sram_keep), .lp_reg_run(lp_reg_run), .irq_pend(irq_pend),
        .wake_event(wake_event), .exti_pend(exti_pend), .exti_mask(exti_mask),
        .periph_wake(periph_wake), .wkup_pin(wkup_pin), .rtc_evt(rtc_evt),
        .tamp_evt(tamp_evt), .pin_rst_req(pin_rst_req), .wdg_rst_req(wdg_rst_req),
        .cur_mode(cur_mode), .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en),
        .hs_osc_en(hs_osc_en), .lsi_en(lsi_en), .lse_en(lse_en), .main_reg_en(main_reg_en),
        .lp_reg_en(lp_reg_en), .sram_ret_en(sram_ret_en), .wake_clk_sel(wake_clk_sel),
        .sys_reset_req(sys_reset_req), .stby_flag(stby_flag), .mode_reserved(mode_reserved)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // {deep, sel[2:0], keep, lpr, req[1:0] (0 wfi,1 wfe,2 isr), exp_mode[3:0], exp_mr, exp_sram}
    localparam logic [13:0] VEC [10] = '{
        14'b0_000_0_0_00_0010_1_1,  // R2 wfi -> sleep
        14'b0_000_0_0_10_0010_1_1,  // R2 isr exit -> sleep
        14'b0_000_0_1_01_0011_0_1,  // R5 lp sleep
        14'b1_000_0_0_00_0100_1_1,  // R6 stop0
        14'b1_001_0_0_00_0101_0_1,  // R6 stop1
        14'b1_010_0_0_00_0101_0_1,  // R11 reserved
        14'b1_011_1_0_00_0110_0_1,  // R8 standby keep
        14'b1_011_0_0_00_0110_0_0,  // R8 standby lose
        14'b1_100_0_0_00_0111_0_0,  // R9 shutdown
        14'b1_111_0_0_01_0111_0_0   // R9 shutdown via wfe
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_in();
        sleep_wfi = 0; sleep_wfe = 0; sleep_isr_exit = 0; deep_sleep = 0; lpm_sel = 0;
        sram_keep = 0; lp_reg_run = 0; irq_pend = 0; wake_event = 0; exti_pend = 0;
        exti_mask = 0; periph_wake = 0; wkup_pin = 0; rtc_evt = 0; tamp_evt = 0;
        pin_rst_req = 0; wdg_rst_req = 0;
    endtask

    task automatic do_reset();
        clear_in();
        rst = 1;
        tick(); tick();
        rst = 0;
    endtask

    task automatic pulse(input logic [1:0] kind);
        sleep_wfi = (kind == 2'd0);
        sleep_wfe = (kind == 2'd1);
        sleep_isr_exit = (kind == 2'd2);
        tick();
        sleep_wfi = 0; sleep_wfe = 0; sleep_isr_exit = 0;
    endtask

    task automatic enter_deep(input logic [2:0] sel, input logic keep);
        deep_sleep = 1; lpm_sel = sel; sram_keep = keep;
        pulse(2'd0);
    endtask

    initial begin
        rst = 1;
        clear_in();
        do_reset();

        // R1 reset state
        check("R1 mode", cur_mode, 0);
        check("R1 knobs", {cpu_clk_en, sys_clk_en, hs_osc_en, lsi_en, lse_en,
                           main_reg_en, lp_reg_en, sram_ret_en}, 8'hFF);
        check("R1 flags", {wake_clk_sel, sys_reset_req, stby_flag, mode_reserved}, 0);

        for (int i = 0; i < 10; i++) begin
            logic [13:0] v;
            v = VEC[i];
            do_reset();
            deep_sleep = v[13]; lpm_sel = v[12:10]; sram_keep = v[9]; lp_reg_run = v[8];
            tick();
            pulse(v[7:6]);
            check($sformatf("R2/R5/R6/R8/R9 vec%0d mode", i), cur_mode, v[5:2]);
            check($sformatf("R6/R8 vec%0d main_reg", i), main_reg_en, v[1]);
            check($sformatf("R8/R9 vec%0d sram", i), sram_ret_en, v[0]);
            if (i == 5) check("R11 reserved flag", mode_reserved, 1);
            if (i == 3) check("R11 no flag for 000", mode_reserved, 0);
        end

        // R2 interrupt wakes sleep
        do_reset();
        pulse(2'd0);
        check("R2 cpu gated", {cpu_clk_en, sys_clk_en}, 2'b01);
        irq_pend = 8'h10;
        tick();
        check("R2 irq wake", cur_mode, 0);
        check("R2 no reset", sys_reset_req, 0);

        // R3 event-only sleep
        do_reset();
        pulse(2'd1);
        irq_pend = 8'h01;
        tick();
        check("R3 irq ignored", cur_mode, 2);
        wake_event = 1;
        tick();
        check("R3 event wake", cur_mode, 0);

        // R4 low-power run
        do_reset();
        lp_reg_run = 1;
        tick();
        check("R4 lprun", cur_mode, 1);
        check("R4 regs/clk", {main_reg_en, lp_reg_en, cpu_clk_en, sys_clk_en}, 4'b0111);
        lp_reg_run = 0;
        tick();
        check("R4 back to run", cur_mode, 0);

        // R5 low-power sleep wake back to low-power run
        do_reset();
        lp_reg_run = 1;
        tick();
        pulse(2'd0);
        check("R5 lpsleep", {cur_mode, cpu_clk_en, main_reg_en}, {4'd3, 2'b00});
        irq_pend = 8'h80;
        tick();
        check("R5 wake to lprun", cur_mode, 1);

        // R7 stop wake qualification
        do_reset();
        enter_deep(3'b001, 0);
        check("R7 wake clock hsi", wake_clk_sel, 1);
        exti_pend = 16'h0004; exti_mask = 16'hFFFB;
        tick();
        check("R7 masked line ignored", cur_mode, 5);
        irq_pend = 8'hFF;
        tick();
        check("R7 irq ignored in stop", cur_mode, 5);
        irq_pend = 0;
        periph_wake = 1;
        tick();
        check("R7 periph wake", cur_mode, 0);
        check("R12 no reset from stop", {sys_reset_req, stby_flag}, 0);
        do_reset();
        enter_deep(3'b000, 0);
        exti_mask = 16'h8000; exti_pend = 16'h8000;
        tick();
        check("R7 enabled line wake", cur_mode, 0);

        // R10 standby via wdg, R12 reset pulse length
        do_reset();
        enter_deep(3'b011, 1);
        check("R10 standby wake clk", wake_clk_sel, 2);
        check("R8 regs off", {main_reg_en, lp_reg_en, lsi_en, lse_en}, 4'b0011);
        wdg_rst_req = 1;
        tick();
        wdg_rst_req = 0;
        check("R10 wdg wakes standby", cur_mode, 8);
        check("R12 reset req", sys_reset_req, 1);
        check("R12 flag set", stby_flag, 1);
        for (int k = 1; k < RST_CYCLES; k++) begin
            tick();
            check("R12 reset held", sys_reset_req, 1);
        end
        tick();
        check("R12 reset ends", {cur_mode, sys_reset_req}, 0);
        check("R12 flag sticky", stby_flag, 1);

        // R10 shutdown ignores wdg, wakes on pin edge
        do_reset();
        enter_deep(3'b101, 0);
        wdg_rst_req = 1;
        tick();
        check("R10 wdg ignored in shutdown", cur_mode, 7);
        wdg_rst_req = 0;
        wkup_pin = 2'b10;
        tick();
        check("R10 pin edge wakes shutdown", cur_mode, 8);

        // R10 standby wakes on rtc
        do_reset();
        enter_deep(3'b011, 0);
        tick();
        check("R10 standby idle", cur_mode, 6);
        rtc_evt = 1;
        tick();
        check("R10 rtc wakes standby", cur_mode, 8);

        // R13 deep entry hold-off
        do_reset();
        tamp_evt = 1;
        enter_deep(3'b011, 0);
        check("R13 held off", cur_mode, 0);
        tamp_evt = 0;
        pulse(2'd0);
        check("R13 entry after clear", cur_mode, 6);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                if (!done) begin
                    checks++;
                    errors++;
                    $display("FAIL watchdog: actual timeout expected completion");
                end
            end
            wait (done);
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule